// File: doc/BRIEF.md
# Rolling Challenge Echo Checker

This block proves, frame by frame, that each of several redundant processors is alive and correctly holding data. Each channel owns an 8-bit linear feedback shift register. The register value is the challenge byte that the serial transport sends to that channel's processor during the current frame. The processor only stores the byte it received and returns it during the next frame. It never computes the sequence itself.

When a frame completes, the transport pulses `frame_done` and presents the returned bytes on `echo_bus`. Each channel compares its returned byte with the challenge it issued one frame earlier and registers a pass/fail flag. It keeps that flag for the whole following frame. In the same cycle it latches the current challenge as the next reference and steps its register once. The channels start from different seeds, so a processor answering on the wrong channel is caught. Right after reset there is no earlier challenge, so the first completed frame always reports failure.

Top module: `echo_guard_bank`

## Requirements
- R1: While `rst` is high, and after it falls before any `frame_done`, the challenges are 0x2A on channel 0, 0x54 on channel 1 and 0xA8 on channel 2. Channel k sits in bits [8k+7:8k] of `challenge_bus` and `echo_bus`. `chan_ok` is 0 and `ok_strobe` is 0.
- R2: Each channel's challenge steps exactly once for each cycle in which `frame_done` is high. The step shifts the byte left and feeds in bit7 XOR bit5 XOR bit4 XOR bit3 as the new bit0, which is the polynomial x^8+x^6+x^5+x^4+1. In every other cycle the challenge is unchanged. The new value appears in the cycle after `frame_done`.
- R3: At the first `frame_done` after reset, every bit of `chan_ok` becomes 0, whatever the echo.
- R4: At any later `frame_done`, `chan_ok[k]` becomes 1 exactly when the echo byte of channel k equals the challenge that channel presented during the previous frame. The flag appears in the cycle after `frame_done`.
- R5: `chan_ok` holds its value in every cycle without `frame_done`.
- R6: `ok_strobe` is high for exactly the one cycle after each `frame_done` cycle and low otherwise.
- R7: No challenge byte is ever 0x00. If a register were ever found at zero, it would reload its seed.
- R8: Each channel's challenge sequence repeats after exactly 255 frames.
- R9: A mismatch on one channel does not affect the flag of any other channel.
- R10: An echo equal to the challenge presented in the same frame is rejected. Only the byte from the previous frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle pulse marking the end of a frame; echoes are valid in this cycle |
| echo_bus | input | 24 | Returned bytes, channel k in bits [8k+7:8k] |
| challenge_bus | output | 24 | Challenge bytes to transmit in the current frame, channel k in bits [8k+7:8k] |
| chan_ok | output | 3 | Per-channel pass flag for the most recently completed frame |
| ok_strobe | output | 1 | One-cycle pulse after each frame completion |

## Verification
At a `frame_done` edge, three things happen in the same cycle: the comparison against the stored reference, the overwrite of that reference with the current challenge, and the register step. The comparison must use the old reference. The bench provokes this by issuing `frame_done` on consecutive cycles with correct and corrupted echoes. A scoreboard model predicts each flag from the byte issued one frame earlier. A second collision comes from raising `rst` in the same cycle as `frame_done`. Reset must win, and the bench judges this by checking the seeds, cleared flags and the first-frame rejection that follow.

// File: rtl/echo_guard_pkg.sv
package echo_guard_pkg;

  localparam int unsigned LFSR_W_DEF = 8;
  // bits 7,5,4,3 feed back: x^8 + x^6 + x^5 + x^4 + 1
  localparam logic [LFSR_W_DEF-1:0] TAP_MASK_DEF  = 8'hB8;
  localparam logic [LFSR_W_DEF-1:0] BASE_SEED_DEF = 8'h2A;

  typedef enum logic {
    REF_EMPTY = 1'b0,
    REF_ARMED = 1'b1
  } ref_state_e;

endpackage

// File: rtl/prbs8_gen.sv
module prbs8_gen #(
  parameter int unsigned     W        = 8,
  parameter logic [W-1:0]    TAP_MASK = 8'hB8,
  parameter logic [W-1:0]    SEED     = 8'h2A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  output logic [W-1:0] state
);

  logic [W-1:0] state_q;
  logic         fb;
  logic [W-1:0] state_nxt;

  assign fb        = ^(state_q & TAP_MASK);
  assign state_nxt = {state_q[W-2:0], fb};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (state_q == '0) begin
      state_q <= SEED;             // lock-up escape
    end else if (advance) begin
      state_q <= state_nxt;
    end
  end

  assign state = state_q;

  assert_never_zero_R7: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(state_q));

  assert_moves_R2: assert property (@(posedge clk) disable iff (rst)
    advance |=> state_q != $past(state_q));

endmodule

// File: rtl/echo_cmp.sv
module echo_cmp import echo_guard_pkg::*; #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] sent,
  input  logic [W-1:0] echo,
  output logic         ok
);

  logic [W-1:0] ref_q;
  ref_state_e   st_q;
  logic         ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      st_q  <= REF_EMPTY;
      ok_q  <= 1'b0;
    end else if (load) begin
      ok_q  <= (st_q == REF_ARMED) && (echo == ref_q);
      ref_q <= sent;
      st_q  <= REF_ARMED;
    end
  end

  assign ok = ok_q;

  assert_first_invalid_R3: assert property (@(posedge clk) disable iff (rst)
    (load && st_q == REF_EMPTY) |=> !ok_q);

  assert_hold_flag_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ok_q));

endmodule

// File: rtl/echo_guard_lane.sv
module echo_guard_lane #(
  parameter int unsigned  W         = 8,
  parameter int unsigned  IDX       = 0,
  parameter logic [W-1:0] TAP_MASK  = 8'hB8,
  parameter logic [W-1:0] BASE_SEED = 8'h2A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_done,
  input  logic [W-1:0] echo,
  output logic [W-1:0] challenge,
  output logic         ok
);

  localparam int unsigned ROT = IDX % W;
  // seed of lane k is the base seed rotated left by k
  localparam logic [W-1:0] SEED = (BASE_SEED << ROT) | (BASE_SEED >> (W - ROT));

  logic [W-1:0] chal;
  logic         ok_w;

  prbs8_gen #(.W(W), .TAP_MASK(TAP_MASK), .SEED(SEED)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .advance (frame_done),
    .state   (chal)
  );

  echo_cmp #(.W(W)) u_cmp (
    .clk  (clk),
    .rst  (rst),
    .load (frame_done),
    .sent (chal),
    .echo (echo),
    .ok   (ok_w)
  );

  assign challenge = chal;
  assign ok        = ok_w;

  assert_no_loopback_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_done && echo == chal) |=> !ok_w);

endmodule

// File: rtl/echo_guard_bank.sv
module echo_guard_bank import echo_guard_pkg::*; #(
  parameter int unsigned  NUM_CH    = 3,
  parameter int unsigned  W         = LFSR_W_DEF,
  parameter logic [W-1:0] TAP_MASK  = TAP_MASK_DEF,
  parameter logic [W-1:0] BASE_SEED = BASE_SEED_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_done,
  input  logic [NUM_CH*W-1:0] echo_bus,
  output logic [NUM_CH*W-1:0] challenge_bus,
  output logic [NUM_CH-1:0]   chan_ok,
  output logic                ok_strobe
);

  logic strobe_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    echo_guard_lane #(
      .W         (W),
      .IDX       (k),
      .TAP_MASK  (TAP_MASK),
      .BASE_SEED (BASE_SEED)
    ) u_lane (
      .clk        (clk),
      .rst        (rst),
      .frame_done (frame_done),
      .echo       (echo_bus[k*W +: W]),
      .challenge  (challenge_bus[k*W +: W]),
      .ok         (chan_ok[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= frame_done;
  end

  assign ok_strobe = strobe_q;

  assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> ok_strobe);

  assert_strobe_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> !ok_strobe);

  assert_flags_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(chan_ok));

endmodule

// File: tb/echo_guard_bank_tb.sv
`timescale 1ns/1ps
module echo_guard_bank_tb;

  localparam int NCH = 3;
  localparam int W   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frame_done = 1'b0;
  logic [NCH*W-1:0]  echo_bus = '0;
  logic [NCH*W-1:0]  challenge_bus;
  logic [NCH-1:0]    chan_ok;
  logic              ok_strobe;

  always #2 clk = ~clk;

  echo_guard_bank u_dut (
    .clk           (clk),
    .rst           (rst),
    .frame_done    (frame_done),
    .echo_bus      (echo_bus),
    .challenge_bus (challenge_bus),
    .chan_ok       (chan_ok),
    .ok_strobe     (ok_strobe)
  );

  typedef struct {
    logic [NCH-1:0]   ok;
    logic [NCH*W-1:0] chal;
    string            tag;
  } exp_t;

  exp_t exp_q[$];

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [7:0]     m_cur  [NCH];
  logic [7:0]     m_prev [NCH];
  bit             m_armed;
  logic [NCH-1:0] m_ok;

  localparam logic [NCH*W-1:0] SEEDS = 24'hA8542A;

  function automatic logic [7:0] lstep(input logic [7:0] b);
    return {b[6:0], b[7] ^ b[5] ^ b[4] ^ b[3]};
  endfunction

  function automatic logic [NCH*W-1:0] pack_cur();
    logic [NCH*W-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*W +: W] = m_cur[k];
    return v;
  endfunction

  function automatic logic [NCH*W-1:0] pack_prev();
    logic [NCH*W-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*W +: W] = m_prev[k];
    return v;
  endfunction

  task automatic check_eq(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cur[0] = 8'h2A; m_cur[1] = 8'h54; m_cur[2] = 8'hA8;
    for (int k = 0; k < NCH; k++) m_prev[k] = 8'h00;
    m_armed = 0;
    m_ok    = '0;
  endtask

  // idle cycles: flags and challenges must hold, strobe must stay low
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_eq("R5", "chan_ok held", 32'(chan_ok), 32'(m_ok));
      check_eq("R2", "challenge held", 32'(challenge_bus), 32'(pack_cur()));
      check_eq("R6", "strobe low", 32'(ok_strobe), 32'd0);
    end
  endtask

  // driver: predict, push, then pulse frame_done (called at a negedge)
  task automatic frame(input logic [NCH*W-1:0] echo, input string tag, input int gap);
    exp_t it;
    for (int k = 0; k < NCH; k++)
      it.ok[k] = m_armed && (echo[k*W +: W] == m_prev[k]);
    for (int k = 0; k < NCH; k++) begin
      m_prev[k] = m_cur[k];
      m_cur[k]  = lstep(m_cur[k]);
    end
    m_armed = 1;
    m_ok    = it.ok;
    it.chal = pack_cur();
    it.tag  = tag;
    exp_q.push_back(it);
    frame_done = 1'b1;
    echo_bus   = echo;
    @(negedge clk);
    frame_done = 1'b0;
    echo_bus   = ~echo;
    idle(gap);
  endtask

  // monitor: pop and compare on every strobe
  always @(negedge clk) begin
    if (ok_strobe) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 unexpected strobe: actual=1 expected=0");
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        check_eq(it.tag, "chan_ok", 32'(chan_ok), 32'(it.ok));
        check_eq("R2", "challenge step", 32'(challenge_bus), 32'(it.chal));
        for (int k = 0; k < NCH; k++)
          check_eq("R7", "challenge nonzero", 32'(challenge_bus[k*W +: W] != 8'h00), 32'd1);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1", "seeds in reset", 32'(challenge_bus), 32'(SEEDS));
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "seeds", 32'(challenge_bus), 32'(SEEDS));
    check_eq("R1", "chan_ok", 32'(chan_ok), 32'd0);
    check_eq("R1", "strobe", 32'(ok_strobe), 32'd0);
    idle(2);

    // first frame: even a plausible echo must fail
    frame(pack_cur(), "R3", 2);
    frame(pack_prev() == 24'h0 ? pack_cur() : pack_prev(), "R4", 3);
    frame(pack_prev() ^ 24'h000100, "R9", 2);
    frame(pack_cur(), "R10", 2);
    // back-to-back frames: compare and reference overwrite in the same edge
    frame(pack_prev(), "R4", 0);
    frame(pack_prev() ^ 24'h800000, "R9", 0);
    frame(pack_prev(), "R4", 0);
    frame(pack_prev() ^ 24'h000001, "R9", 5);
    frame(pack_prev(), "R5", 4);

    // reset arriving together with frame_done: reset wins
    rst = 1'b1;
    frame_done = 1'b1;
    echo_bus = pack_prev();
    @(negedge clk);
    rst = 1'b0;
    frame_done = 1'b0;
    model_reset();
    exp_q.delete();
    @(negedge clk);
    check_eq("R1", "seeds after reset+frame", 32'(challenge_bus), 32'(SEEDS));
    check_eq("R1", "chan_ok after reset+frame", 32'(chan_ok), 32'd0);
    check_eq("R1", "strobe after reset+frame", 32'(ok_strobe), 32'd0);
    frame(pack_cur(), "R3", 1);

    // full period with occasional single-channel corruption
    for (int i = 1; i < 255; i++) begin
      if (i % 5 == 2)
        frame(pack_prev() ^ (24'h000004 << (8 * (i % 3))), "R9", i % 3);
      else
        frame(pack_prev(), "R4", i % 3);
    end
    check_eq("R8", "sequence wraps after 255 frames", 32'(challenge_bus), 32'(SEEDS));

    idle(3);
    check_eq("R6", "every frame strobed", 32'(exp_q.size()), 32'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule